// File: doc/BRIEF.md
# Switchable-Width Register File

This block holds the accumulator and the index registers of a small processor core. Each register is stored as two bytes. Two status flags and an emulation flag decide how wide each register looks at the ports. The accumulator width flag also tells a bus sequencer whether an accumulator or memory transfer takes one byte cycle or two.

In emulation mode both width flags are pinned to "narrow". A hidden accumulator high byte keeps its value across narrow operation and can be exchanged with the low byte at any time. The index high bytes are zero whenever the index registers are narrow. Commands arrive as single-cycle inputs:
- a register write (target plus value),
- a clear-flags mask and a set-flags mask,
- a mode-exchange strobe that trades the emulation flag with carry,
- a byte-swap strobe for the accumulator.

Every command takes effect on the next rising clock edge.

Top module: `wrf_regfile`

## Requirements
- R1: A synchronous reset gives emulation flag 1, m 1, x 1, carry 0, and all register bytes zero. It takes precedence over every command in the same cycle.
- R2: Status mask bit 5 is m (accumulator width) and bit 4 is x (index width), where 0 means 16 bits and 1 means 8 bits. Outside emulation, the clear and set masks change m and x independently. If both masks name the same bit, the set wins.
- R3: While the emulation flag is 1, m and x stay at 1, and a clear mask has no effect on them. The clear mask is judged against the emulation flag held before the edge.
- R4: The swap strobe exchanges the accumulator high byte (B) and low byte (A) in every mode. An accumulator write in the same cycle overrides the swapped value.
- R5: The index high bytes read zero whenever x is 1. When x becomes 1, by a set mask or by entering emulation, both high bytes clear on that same edge. A write while x is 0 stores all 16 bits, and the write width follows the x held before the edge.
- R6: While m is 1, an accumulator write changes only A and keeps B, and the accumulator output shows zero in its high byte. While m is 0, a write stores both bytes and the output shows {B, A}.
- R7: The memory cycle output is 1 while m is 1 and 2 while m is 0.
- R8: The mode-exchange strobe loads the emulation flag from the carry produced by the masks, and loads carry with the old emulation flag. Mask bit 0 is carry. Entering emulation forces m and x to 1 on the same edge. Leaving emulation keeps B.
- R9: The write select code is 0 for the accumulator, k+1 for index register k (1 is X, 2 is Y). The remaining code writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W (2) | Write target code |
| wr_data_i | input | WORD_W (16) | Write value |
| clr_mask_i | input | 8 | Status bits to clear |
| set_mask_i | input | 8 | Status bits to set |
| xchg_i | input | 1 | Exchange carry with emulation flag |
| swap_i | input | 1 | Exchange accumulator bytes |
| acc_o | output | WORD_W (16) | Visible accumulator |
| idx_o | output | NUM_IDX*WORD_W (32) | Index registers, register k at bits [k*WORD_W +: WORD_W] |
| m_flag_o | output | 1 | Accumulator width flag |
| x_flag_o | output | 1 | Index width flag |
| emu_flag_o | output | 1 | Emulation flag |
| carry_o | output | 1 | Carry flag |
| mem_cycles_o | output | 2 | Byte cycles per accumulator or memory transfer |

## Verification
The bench builds the block with the default byte width of 8 and two index registers. With these values the select field has exactly one unused code, so the write-nothing case (R9) is reachable. X and Y can be told apart by their packed position. A vector table drives the block through both ways of entering and leaving emulation, mixed widths, and set-wins mask conflicts. Directed steps then cover a swap and a write in the same cycle, a mask applied together with a mode exchange, and a reset in the middle of the run.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    // status word layout
    localparam int STATUS_W = 8;
    localparam int C_POS    = 0;
    localparam int X_POS    = 4;
    localparam int M_POS    = 5;

    typedef struct packed {
        logic emu;
        logic m;
        logic x;
        logic c;
    } mode_t;

    localparam mode_t MODE_RESET = '{emu: 1'b1, m: 1'b1, x: 1'b1, c: 1'b0};
endpackage

// File: rtl/wrf_mode_ctrl.sv
module wrf_mode_ctrl
    import wrf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STATUS_W-1:0] clr_mask_i,
    input  logic [STATUS_W-1:0] set_mask_i,
    input  logic                xchg_i,
    output logic                emu_o,
    output logic                m_o,
    output logic                x_o,
    output logic                x_next_o,
    output logic                c_o
);
    mode_t mode_d, mode_q;
    logic  unused_mask_bits;

    assign unused_mask_bits = ^{clr_mask_i, set_mask_i};

    always_comb begin
        mode_d = mode_q;
        // carry follows the masks in every mode
        if (clr_mask_i[C_POS]) mode_d.c = 1'b0;
        if (set_mask_i[C_POS]) mode_d.c = 1'b1;
        // width flags may only be cleared in native mode
        if (!mode_q.emu) begin
            if (clr_mask_i[M_POS]) mode_d.m = 1'b0;
            if (clr_mask_i[X_POS]) mode_d.x = 1'b0;
        end
        if (set_mask_i[M_POS]) mode_d.m = 1'b1;
        if (set_mask_i[X_POS]) mode_d.x = 1'b1;
        // exchange uses the carry after the masks
        if (xchg_i) begin
            mode_d.emu = mode_d.c;
            mode_d.c   = mode_q.emu;
        end
        if (mode_d.emu) begin
            mode_d.m = 1'b1;
            mode_d.x = 1'b1;
        end
        if (rst) mode_d = MODE_RESET;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign emu_o    = mode_q.emu;
    assign m_o      = mode_q.m;
    assign x_o      = mode_q.x;
    assign c_o      = mode_q.c;
    assign x_next_o = mode_d.x;

    AST_EMU_PINS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        emu_o |-> (m_o && x_o)); // R3

    AST_M_CLEAR_ALONE: assert property (@(posedge clk) disable iff (rst)
        (!emu_o && !xchg_i && clr_mask_i[M_POS] && !set_mask_i[M_POS]
         && !clr_mask_i[X_POS] && !set_mask_i[X_POS])
        |=> (!m_o && x_o == $past(x_o))); // R2

    AST_XCHG_TRADES: assert property (@(posedge clk) disable iff (rst)
        (xchg_i && !clr_mask_i[C_POS] && !set_mask_i[C_POS])
        |=> (emu_o == $past(c_o) && c_o == $past(emu_o))); // R8
endmodule

// File: rtl/wrf_accum.sv
module wrf_accum #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              swap_i,
    output logic [WORD_W-1:0] acc_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (swap_i) begin
            acc_d.lo = acc_q.hi;
            acc_d.hi = acc_q.lo;
        end
        if (wr_i) begin
            acc_d.lo = wr_data_i[BYTE_W-1:0];
            if (wide_i) acc_d.hi = wr_data_i[WORD_W-1:BYTE_W];
        end
        if (rst) acc_d = '0;
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    assign acc_o = wide_i ? {acc_q.hi, acc_q.lo} : {{BYTE_W{1'b0}}, acc_q.lo};

    AST_SWAP_EXCHANGES: assert property (@(posedge clk) disable iff (rst)
        (swap_i && !wr_i) |=> (acc_q.lo == $past(acc_q.hi) && acc_q.hi == $past(acc_q.lo))); // R4

    AST_NARROW_WRITE_KEEPS_B: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !wide_i && !swap_i) |=> (acc_q.hi == $past(acc_q.hi))); // R6
endmodule

// File: rtl/wrf_index_lane.sv
module wrf_index_lane #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              narrow_q_i,
    input  logic              narrow_d_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] val_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } idx_t;

    idx_t idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (wr_i) begin
            idx_d.lo = wr_data_i[BYTE_W-1:0];
            if (!narrow_q_i) idx_d.hi = wr_data_i[WORD_W-1:BYTE_W];
        end
        if (narrow_d_i) idx_d.hi = '0;
        if (rst) idx_d = '0;
    end

    always_ff @(posedge clk) begin
        idx_q <= idx_d;
    end

    assign val_o = {idx_q.hi, idx_q.lo};

    AST_IDX_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        narrow_q_i |-> (val_o[WORD_W-1:BYTE_W] == '0)); // R5

    AST_IDX_WIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !narrow_q_i && !narrow_d_i) |=> (val_o == $past(wr_data_i))); // R5
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile
    import wrf_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int NUM_IDX = 2,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int SEL_W  = $clog2(NUM_IDX + 2)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic [SEL_W-1:0]          wr_sel_i,
    input  logic [WORD_W-1:0]         wr_data_i,
    input  logic [STATUS_W-1:0]       clr_mask_i,
    input  logic [STATUS_W-1:0]       set_mask_i,
    input  logic                      xchg_i,
    input  logic                      swap_i,
    output logic [WORD_W-1:0]         acc_o,
    output logic [NUM_IDX*WORD_W-1:0] idx_o,
    output logic                      m_flag_o,
    output logic                      x_flag_o,
    output logic                      emu_flag_o,
    output logic                      carry_o,
    output logic [1:0]                mem_cycles_o
);
    logic x_next;
    logic acc_wr;

    wrf_mode_ctrl i_mode (
        .clk        (clk),
        .rst        (rst),
        .clr_mask_i (clr_mask_i),
        .set_mask_i (set_mask_i),
        .xchg_i     (xchg_i),
        .emu_o      (emu_flag_o),
        .m_o        (m_flag_o),
        .x_o        (x_flag_o),
        .x_next_o   (x_next),
        .c_o        (carry_o)
    );

    assign acc_wr = wr_en_i && (wr_sel_i == '0);

    wrf_accum #(.BYTE_W(BYTE_W)) i_accum (
        .clk       (clk),
        .rst       (rst),
        .wide_i    (!m_flag_o),
        .wr_i      (acc_wr),
        .wr_data_i (wr_data_i),
        .swap_i    (swap_i),
        .acc_o     (acc_o)
    );

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_lane
        logic lane_wr;
        assign lane_wr = wr_en_i && (wr_sel_i == SEL_W'(k + 1));
        wrf_index_lane #(.BYTE_W(BYTE_W)) i_lane (
            .clk        (clk),
            .rst        (rst),
            .narrow_q_i (x_flag_o),
            .narrow_d_i (x_next),
            .wr_i       (lane_wr),
            .wr_data_i  (wr_data_i),
            .val_o      (idx_o[k*WORD_W +: WORD_W])
        );
    end

    assign mem_cycles_o = m_flag_o ? 2'd1 : 2'd2;

    AST_NARROW_ACC_HIDES_B: assert property (@(posedge clk) disable iff (rst)
        (mem_cycles_o == 2'd1) |-> (acc_o[WORD_W-1:BYTE_W] == '0)); // R7
endmodule

// File: tb/test_wrf_regfile.sv
module test_wrf_regfile;
    localparam int BYTE_W = 8;
    localparam int NUM_IDX = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  clr_mask = '0;
    logic [7:0]  set_mask = '0;
    logic        xchg = 1'b0;
    logic        swap = 1'b0;
    logic [15:0] acc;
    logic [31:0] idx;
    logic        m_f, x_f, e_f, c_f;
    logic [1:0]  cyc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wrf_regfile #(.BYTE_W(BYTE_W), .NUM_IDX(NUM_IDX)) i_wrf_regfile (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .clr_mask_i(clr_mask), .set_mask_i(set_mask), .xchg_i(xchg), .swap_i(swap),
        .acc_o(acc), .idx_o(idx), .m_flag_o(m_f), .x_flag_o(x_f), .emu_flag_o(e_f),
        .carry_o(c_f), .mem_cycles_o(cyc)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sel;
        logic [15:0] data;
        logic [7:0]  clr;
        logic [7:0]  set;
        logic        xc;
        logic        sw;
        logic [15:0] e_acc;
        logic [15:0] e_x;
        logic [15:0] e_y;
        logic [3:0]  e_fl;   // {m, x, emu, carry}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 16'h1234, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0034, 16'h0000, 16'h0000, 4'b1110, 4'd6}, // R6 narrow write
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 4'b1110, 4'd4}, // R4 swap in emulation
        '{1'b1, 2'd0, 16'h00AB, 8'h00, 8'h00, 1'b0, 1'b0, 16'h00AB, 16'h0000, 16'h0000, 4'b1110, 4'd6},
        '{1'b0, 2'd0, 16'h0000, 8'h30, 8'h00, 1'b0, 1'b0, 16'h00AB, 16'h0000, 16'h0000, 4'b1110, 4'd3}, // R3 clear ignored
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 16'h00AB, 16'h0000, 16'h0000, 4'b1101, 4'd8}, // R8 enter native
        '{1'b0, 2'd0, 16'h0000, 8'h20, 8'h00, 1'b0, 1'b0, 16'h34AB, 16'h0000, 16'h0000, 4'b0101, 4'd8}, // R8 B kept
        '{1'b1, 2'd1, 16'hBEEF, 8'h00, 8'h00, 1'b0, 1'b0, 16'h34AB, 16'h00EF, 16'h0000, 4'b0101, 4'd5}, // R5 narrow X
        '{1'b0, 2'd0, 16'h0000, 8'h10, 8'h00, 1'b0, 1'b0, 16'h34AB, 16'h00EF, 16'h0000, 4'b0001, 4'd2},
        '{1'b1, 2'd2, 16'hBEEF, 8'h00, 8'h00, 1'b0, 1'b0, 16'h34AB, 16'h00EF, 16'hBEEF, 4'b0001, 4'd5},
        '{1'b1, 2'd0, 16'h5678, 8'h00, 8'h00, 1'b0, 1'b0, 16'h5678, 16'h00EF, 16'hBEEF, 4'b0001, 4'd6},
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b1, 16'h7856, 16'h00EF, 16'hBEEF, 4'b0001, 4'd4},
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h20, 1'b0, 1'b0, 16'h0056, 16'h00EF, 16'hBEEF, 4'b1001, 4'd2}, // R2 m alone
        '{1'b1, 2'd1, 16'h1357, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0056, 16'h1357, 16'hBEEF, 4'b1001, 4'd5},
        '{1'b1, 2'd3, 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0056, 16'h1357, 16'hBEEF, 4'b1001, 4'd9}, // R9 code 3
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h10, 1'b0, 1'b0, 16'h0056, 16'h0057, 16'h00EF, 4'b1101, 4'd5}, // R5 set x clears
        '{1'b0, 2'd0, 16'h0000, 8'h30, 8'h00, 1'b0, 1'b0, 16'h7856, 16'h0057, 16'h00EF, 4'b0001, 4'd2},
        '{1'b1, 2'd1, 16'hCAFE, 8'h00, 8'h00, 1'b0, 1'b0, 16'h7856, 16'hCAFE, 16'h00EF, 4'b0001, 4'd5},
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0056, 16'h00FE, 16'h00EF, 4'b1110, 4'd8}, // R8 enter emulation
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0078, 16'h00FE, 16'h00EF, 4'b1110, 4'd4},
        '{1'b0, 2'd0, 16'h0000, 8'h31, 8'h00, 1'b0, 1'b0, 16'h0078, 16'h00FE, 16'h00EF, 4'b1110, 4'd3},
        '{1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0078, 16'h00FE, 16'h00EF, 4'b1101, 4'd8},
        '{1'b0, 2'd0, 16'h0000, 8'h20, 8'h20, 1'b0, 1'b0, 16'h0078, 16'h00FE, 16'h00EF, 4'b1101, 4'd2}, // R2 set wins
        '{1'b0, 2'd0, 16'h0000, 8'h20, 8'h00, 1'b0, 1'b0, 16'h5678, 16'h00FE, 16'h00EF, 4'b0101, 4'd7}  // R7 two cycles
    };

    task automatic chk(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic [15:0] ea, input logic [15:0] ex,
                             input logic [15:0] ey, input logic [3:0] ef);
        chk("acc", req, acc, ea);
        chk("X", req, idx[15:0], ex);
        chk("Y", req, idx[31:16], ey);
        chk("flags", req, {12'h0, m_f, x_f, e_f, c_f}, {12'h0, ef});
        chk("cycles", 7, {14'h0, cyc}, ef[3] ? 16'd1 : 16'd2); // R7
    endtask

    task automatic drive(input logic w, input logic [1:0] s, input logic [15:0] d,
                         input logic [7:0] cm, input logic [7:0] sm, input logic xc, input logic sw);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d; clr_mask = cm; set_mask = sm; xchg = xc; swap = sw;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0; clr_mask = '0; set_mask = '0; xchg = 1'b0; swap = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all(1, 16'h0000, 16'h0000, 16'h0000, 4'b1110); // R1 reset state

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].sel, VEC[i].data, VEC[i].clr, VEC[i].set, VEC[i].xc, VEC[i].sw);
            check_all(int'(VEC[i].req), VEC[i].e_acc, VEC[i].e_x, VEC[i].e_y, VEC[i].e_fl);
        end

        // R4: write wins over swap in the same cycle (m=0)
        drive(1'b1, 2'd0, 16'h1111, 8'h00, 8'h00, 1'b0, 1'b1);
        check_all(4, 16'h1111, 16'h00FE, 16'h00EF, 4'b0101);

        // R8: clear mask plus exchange in native: emulation forces m,x back to 1
        drive(1'b0, 2'd0, 16'h0000, 8'h30, 8'h00, 1'b1, 1'b0);
        check_all(8, 16'h0011, 16'h00FE, 16'h00EF, 4'b1110);

        // R3: clear mask plus exchange from emulation: gated by old flag
        drive(1'b0, 2'd0, 16'h0000, 8'h30, 8'h00, 1'b1, 1'b0);
        check_all(3, 16'h0011, 16'h00FE, 16'h00EF, 4'b1101);

        // R1: reset mid-run wins over a write in the same cycle
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'hA5A5;
        @(posedge clk);
        #1;
        rst = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        #1;
        check_all(1, 16'h0000, 16'h0000, 16'h0000, 4'b1110);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule